// File: doc/BRIEF.md
# USB Host Root-Port Control/Status Register

This block is the 32-bit control and status word for one USB host root port. Software reaches it over a plain write strobe with a 32-bit data word, and it reads the current value back on a 32-bit read bus. Hardware event inputs feed into the same word: the attach level, the overcurrent level, a remote-wakeup pulse, the line levels and the detected device speed. On every cycle the block merges a software write with whatever these events imply.

Some fields are plain read/write: reset drive, test pattern select and power. Some are read-only mirrors of port state. Three change flags are raised only by hardware and are cleared by writing 1 to them. The enable bit can only be set by hardware and is cleared by writing 1 to it. Suspend, resume and power can also be overridden by hardware events. The three change flags are ORed onto a single port interrupt. A one-cycle strobe marks the end of a port reset. On the cycle after that strobe the port becomes enabled, provided a device is still attached and no overcurrent is present.

Top module: `usbHostPortReg`

## Requirements
- R1: After reset, the read word, the interrupt output and the reset-done strobe are all 0.
- R2: Bit 8 (reset drive) and bits 16:13 (test select, 0 off, 1 J, 2 K, 3 SE0_NAK, 4 Packet, 5 Force_Enable) take the written value. Bit 9 and bits 31:19 always read 0. Writes to bit 0 and bit 4 have no effect.
- R3: Bit 0 shows the attach input one cycle after it is sampled. Bit 1 (connect detected) is set when the attach input goes from 0 to 1.
- R4: Bits 1, 3 and 5 are cleared by writing 1, and writing 0 leaves them unchanged. When a hardware set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: Bit 2 (enable) cannot be set by a write. It is cleared by writing 1 to it, by a disconnect, or while the overcurrent input is high. It is set on the cycle after the reset-done strobe if the port is attached and no overcurrent was recorded.
- R6: Bit 3 (enable change) is set on every cycle in which bit 2 changes value.
- R7: Bit 4 shows the overcurrent input one cycle after it is sampled. Bit 5 is set when the overcurrent input rises or falls.
- R8: Bit 12 (power) takes the written value, but it is forced to 0 on every cycle in which the overcurrent input is high.
- R9: Bit 7 (suspend) takes the written value. It is cleared, with priority over the write, by a remote wakeup, by a disconnect, or by any write with bit 8 or bit 6 set. This holds whether or not a device is attached.
- R10: Bit 6 (resume) takes the written value. A remote wakeup sets it. A disconnect clears it, and a disconnect overrides a wakeup in the same cycle.
- R11: Bit 10 shows D+ and bit 11 shows D-. Bits 18:17 show the speed code (00 high, 01 full, 10 low). All three fields are registered one cycle.
- R12: The interrupt output is high exactly when bit 1, bit 3 or bit 5 is set.
- R13: The reset-done output pulses for one cycle, on the cycle after a write clears bit 8 while it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write data |
| devAttached | input | 1 | Device attach level |
| overCurrent | input | 1 | Overcurrent level from the power switch |
| wakeupDet | input | 1 | Remote-wakeup detected pulse |
| lineDp | input | 1 | D+ logic level |
| lineDm | input | 1 | D- logic level |
| devSpeed | input | 2 | Detected device speed code |
| rdData | output | 32 | Current register word |
| portIrq | output | 1 | Port interrupt, OR of the change flags |
| resetDone | output | 1 | One-cycle end-of-port-reset strobe |

## Verification
The hardest cases to reach are same-cycle collisions: a hardware event and a software write landing on the same bit in the same cycle. Examples are an attach edge together with a write-1 clear of connect detected, an overcurrent fall together with a clear of its flag, and a disconnect together with a wakeup while resume is high. The stimulus changes the level inputs on the same falling edge that raises the write strobe, so both are seen at one rising edge. Reaching the enable bit at all takes a full reset write/clear sequence with a device attached, and the bench repeats that sequence before each enable-clearing cause.

// File: rtl/usbHostPortPkg.sv
package usbHostPortPkg;
  localparam int WORD_W    = 32;
  localparam int TEST_W    = 4;
  localparam int SPEED_W   = 2;
  localparam int B_CONN    = 0;
  localparam int B_CDET    = 1;
  localparam int B_ENA     = 2;
  localparam int B_ENCHG   = 3;
  localparam int B_OCACT   = 4;
  localparam int B_OCCHG   = 5;
  localparam int B_RESUME  = 6;
  localparam int B_SUSP    = 7;
  localparam int B_RST     = 8;
  localparam int B_LINE_LO = 10;
  localparam int B_PWR     = 12;
  localparam int B_TEST_LO = 13;
  localparam int B_SPD_LO  = B_TEST_LO + TEST_W;

  typedef struct packed {
    logic connRise;
    logic disconnect;
    logic ocToggle;
    logic ocHold;
    logic wakeup;
    logic enableSet;
    logic suspendKill;
  } portStrobes_t;
endpackage

// File: rtl/usbPortCtrl.sv
module usbPortCtrl
  import usbHostPortPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrRst,
  input  logic         wrResume,
  input  logic         rstBit,
  input  logic         devAttached,
  input  logic         overCurrent,
  input  logic         wakeupDet,
  output logic         connSts,
  output logic         ocAct,
  output logic         resetDone,
  output portStrobes_t st
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      connSts   <= 1'b0;
      ocAct     <= 1'b0;
      resetDone <= 1'b0;
    end else begin
      connSts   <= devAttached;
      ocAct     <= overCurrent;
      resetDone <= wrEn & ~wrRst & rstBit;
    end
  end

  always_comb begin
    st.connRise    = devAttached & ~connSts;
    st.disconnect  = ~devAttached & connSts;
    st.ocToggle    = overCurrent ^ ocAct;
    st.ocHold      = overCurrent;
    st.wakeup      = wakeupDet;
    st.enableSet   = resetDone & connSts & ~ocAct;
    st.suspendKill = wakeupDet | st.disconnect | (wrEn & (wrRst | wrResume));
  end

  // R13: the end-of-reset strobe never lasts more than one cycle
  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |=> !resetDone);
endmodule

// File: rtl/usbPortRegs.sv
module usbPortRegs
  import usbHostPortPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WORD_W-1:0]   wrData,
  input  portStrobes_t        st,
  input  logic                connSts,
  input  logic                ocAct,
  input  logic                lineDp,
  input  logic                lineDm,
  input  logic [SPEED_W-1:0]  devSpeed,
  output logic                rstBit,
  output logic [WORD_W-1:0]   rdData,
  output logic                portIrq
);
  logic               connDet, portEna, enaNext, enChg, ocChg;
  logic               resumeBit, suspendBit, pwrBit;
  logic [TEST_W-1:0]  testSel;
  logic [1:0]         lineSts;
  logic [SPEED_W-1:0] speedQ;

  always_comb begin
    enaNext = portEna;
    if (st.enableSet) enaNext = 1'b1;
    if (st.ocHold || st.disconnect || (wrEn && wrData[B_ENA])) enaNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      connDet    <= 1'b0;
      portEna    <= 1'b0;
      enChg      <= 1'b0;
      ocChg      <= 1'b0;
      resumeBit  <= 1'b0;
      suspendBit <= 1'b0;
      rstBit     <= 1'b0;
      pwrBit     <= 1'b0;
      testSel    <= '0;
      lineSts    <= '0;
      speedQ     <= '0;
    end else begin
      lineSts <= {lineDm, lineDp};
      speedQ  <= devSpeed;
      connDet <= st.connRise | (connDet & ~(wrEn & wrData[B_CDET]));
      portEna <= enaNext;
      enChg   <= (enaNext != portEna) | (enChg & ~(wrEn & wrData[B_ENCHG]));
      ocChg   <= st.ocToggle | (ocChg & ~(wrEn & wrData[B_OCCHG]));

      if (st.disconnect)  resumeBit <= 1'b0;
      else if (st.wakeup) resumeBit <= 1'b1;
      else if (wrEn)      resumeBit <= wrData[B_RESUME];

      if (st.suspendKill) suspendBit <= 1'b0;
      else if (wrEn)      suspendBit <= wrData[B_SUSP];

      if (st.ocHold)      pwrBit <= 1'b0;
      else if (wrEn)      pwrBit <= wrData[B_PWR];

      if (wrEn) begin
        rstBit  <= wrData[B_RST];
        testSel <= wrData[B_TEST_LO +: TEST_W];
      end
    end
  end

  always_comb begin
    rdData = '0;
    rdData[B_CONN]                = connSts;
    rdData[B_CDET]                = connDet;
    rdData[B_ENA]                 = portEna;
    rdData[B_ENCHG]               = enChg;
    rdData[B_OCACT]               = ocAct;
    rdData[B_OCCHG]               = ocChg;
    rdData[B_RESUME]              = resumeBit;
    rdData[B_SUSP]                = suspendBit;
    rdData[B_RST]                 = rstBit;
    rdData[B_LINE_LO +: 2]        = lineSts;
    rdData[B_PWR]                 = pwrBit;
    rdData[B_TEST_LO +: TEST_W]   = testSel;
    rdData[B_SPD_LO +: SPEED_W]   = speedQ;
    portIrq = connDet | enChg | ocChg;
  end

  // R5: enable only ever rises after the control unit requested it
  assert_enable_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portEna) |-> $past(st.enableSet));
  // R8: power is off after any cycle with overcurrent high
  assert_power_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.ocHold |=> !pwrBit);
  // R4: a write-1 clear without a competing attach edge clears the flag
  assert_conn_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[B_CDET] && !st.connRise) |=> !connDet);
  // R9: a suspend-clearing event always wins
  assert_suspend_kill_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.suspendKill |=> !suspendBit);
  // R10: disconnect drops resume drive
  assert_resume_disc_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.disconnect |=> !resumeBit);
endmodule

// File: rtl/usbHostPortReg.sv
module usbHostPortReg
  import usbHostPortPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                devAttached,
  input  logic                overCurrent,
  input  logic                wakeupDet,
  input  logic                lineDp,
  input  logic                lineDm,
  input  logic [SPEED_W-1:0]  devSpeed,
  output logic [WORD_W-1:0]   rdData,
  output logic                portIrq,
  output logic                resetDone
);
  portStrobes_t st;
  logic connSts, ocAct, rstBit;

  usbPortCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrRst(wrData[B_RST]), .wrResume(wrData[B_RESUME]),
    .rstBit(rstBit), .devAttached(devAttached), .overCurrent(overCurrent),
    .wakeupDet(wakeupDet), .connSts(connSts), .ocAct(ocAct),
    .resetDone(resetDone), .st(st)
  );

  usbPortRegs regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .st(st),
    .connSts(connSts), .ocAct(ocAct), .lineDp(lineDp), .lineDm(lineDm),
    .devSpeed(devSpeed), .rstBit(rstBit), .rdData(rdData), .portIrq(portIrq)
  );
endmodule

// File: tb/usbHostPortReg_tb_top.sv
`timescale 1ns/1ps
module usbHostPortReg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        devAttached = 1'b0, overCurrent = 1'b0, wakeupDet = 1'b0;
  logic        lineDp = 1'b0, lineDm = 1'b0;
  logic [1:0]  devSpeed = 2'b00;
  logic [31:0] rdData;
  logic        portIrq, resetDone;
  int          vectors = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  usbHostPortReg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .devAttached(devAttached), .overCurrent(overCurrent), .wakeupDet(wakeupDet),
    .lineDp(lineDp), .lineDm(lineDm), .devSpeed(devSpeed),
    .rdData(rdData), .portIrq(portIrq), .resetDone(resetDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    tick();
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    wrap();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 word", rdData, 32'h0);
    chk("R1 irq", {31'b0, portIrq}, 32'h0);
    chk("R1 done", {31'b0, resetDone}, 32'h0);
    rstN = 1'b1;
    tick();

    // R2 sweep of test select and power, with reserved bits written high
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 2; p++) begin
        wr(32'hFFF8_0200 | (32'(t) << 13) | (32'(p) << 12) | 32'h100);
        chk("R2 rw fields", rdData, (32'(t) << 13) | (32'(p) << 12) | 32'h100);
      end
    end
    wr(32'h0);
    chk("R13 done pulse", {31'b0, resetDone}, 32'h1);
    chk("R2 reset cleared", rdData, 32'h0);
    tick();
    chk("R13 pulse ends", {31'b0, resetDone}, 32'h0);
    chk("R5 no enable without device", rdData, 32'h0);
    wr(32'h0000_003F);
    chk("R2 ro bits and R5 no sw set", rdData, 32'h0);

    // R11 sweep of speed and line levels
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 4; l++) begin
        devSpeed = 2'(s);
        lineDp = l[0];
        lineDm = l[1];
        tick();
        chk("R11 speed/line", rdData, (32'(s) << 17) | (32'(l[1]) << 11) | (32'(l[0]) << 10));
      end
    end
    devSpeed = 2'b00; lineDp = 1'b0; lineDm = 1'b0;
    tick();

    // R3 / R12 attach
    devAttached = 1'b1;
    tick();
    chk("R3 attach", rdData, 32'h3);
    chk("R12 irq on", {31'b0, portIrq}, 32'h1);
    wr(32'h0);
    chk("R4 write 0 keeps flag", rdData, 32'h3);
    wr(32'h2);
    chk("R4 w1c", rdData, 32'h1);
    chk("R12 irq off", {31'b0, portIrq}, 32'h0);

    // R5 / R6 / R13 enable after reset sequence
    wr(32'h100);
    chk("R2 reset set", rdData, 32'h101);
    wr(32'h0);
    chk("R13 pulse", {31'b0, resetDone}, 32'h1);
    chk("R5 not yet enabled", rdData, 32'h1);
    tick();
    chk("R5 R6 enabled", rdData, 32'hD);
    wr(32'h8);
    chk("R4 clear enChg", rdData, 32'h5);
    wr(32'h4);
    chk("R5 sw clear", rdData, 32'h9);
    wr(32'h8);
    chk("R6 cleared", rdData, 32'h1);

    // R4 hw set wins against clear
    devAttached = 1'b0;
    tick();
    chk("R3 detach", rdData, 32'h0);
    devAttached = 1'b1;
    wr(32'h2);
    chk("R4 set wins", rdData, 32'h3);
    wr(32'h2);
    chk("R4 clear after", rdData, 32'h1);

    // R5 disconnect clears enable
    wr(32'h100); wr(32'h0); tick();
    chk("R5 re-enabled", rdData, 32'hD);
    wr(32'h8);
    devAttached = 1'b0;
    tick();
    chk("R5 disconnect clears", rdData, 32'h8);
    wr(32'h8);
    chk("R6 clear", rdData, 32'h0);

    // R7 / R8 overcurrent
    devAttached = 1'b1;
    tick();
    wr(32'h2);
    wr(32'h1000);
    chk("R8 power on", rdData, 32'h1001);
    wr(32'h1100); wr(32'h1000); tick();
    chk("R5 enabled with power", rdData, 32'h100D);
    wr(32'h1008);
    overCurrent = 1'b1;
    tick();
    chk("R7 R8 R5 overcurrent", rdData, 32'h39);
    wr(32'h1028);
    chk("R8 power held off", rdData, 32'h11);
    overCurrent = 1'b0;
    wr(32'h20);
    chk("R7 R4 fall wins", rdData, 32'h21);
    wr(32'h20);
    chk("R7 cleared", rdData, 32'h1);
    wr(32'h1000);
    chk("R8 power again", rdData, 32'h1001);
    wr(32'h0);
    chk("R8 power off", rdData, 32'h1);

    // R9 / R10 suspend and resume
    wr(32'h80);
    chk("R9 suspend set", rdData, 32'h81);
    wakeupDet = 1'b1;
    tick();
    wakeupDet = 1'b0;
    chk("R9 R10 wakeup", rdData, 32'h41);
    wr(32'hC0);
    chk("R9 resume write kills", rdData, 32'h41);
    wr(32'h80);
    chk("R9 suspend again", rdData, 32'h81);
    wr(32'h180);
    chk("R9 reset write kills", rdData, 32'h101);
    wr(32'h0); tick();
    chk("R5 enabled", rdData, 32'hD);
    wr(32'h88);
    chk("R9 suspend on", rdData, 32'h85);
    devAttached = 1'b0;
    tick();
    chk("R9 disconnect kills", rdData, 32'h8);
    wr(32'h8);
    devAttached = 1'b1;
    tick();
    wr(32'h2);
    wr(32'h40);
    chk("R10 resume written", rdData, 32'h41);
    devAttached = 1'b0;
    wakeupDet = 1'b1;
    tick();
    wakeupDet = 1'b0;
    chk("R10 disconnect beats wakeup", rdData, 32'h0);
    wr(32'h80);
    chk("R9 suspend no device", rdData, 32'h80);
    wakeupDet = 1'b1;
    tick();
    wakeupDet = 1'b0;
    chk("R9 R10 wakeup no device", rdData, 32'h40);
    wr(32'h0);
    chk("R10 sw clear", rdData, 32'h0);

    wrap();
  end
endmodule